// File: doc/BRIEF.md
# Multicycle Five-Phase Integer Sequencer

This block is a small integer processor core that runs one instruction at a time, with no overlap. Each instruction walks through a fixed series of clock phases: fetch, decode with register read, execute or address generation, memory access or branch resolution, and write-back. Between phases the values are held in internal scratch registers: the incremented PC, two operand latches, the sign-extended immediate, the ALU result, the branch condition and the loaded word. Stores, branches and unrecognised instructions end after the memory phase and take four cycles. ALU operations and loads go on to write-back and take five cycles.

The core has separate instruction and data word ports. Both memories answer within the cycle in which the address is presented, and the core never stalls on them. For this reason the memory ports carry no valid/ready handshake and cannot apply back-pressure. Instruction addresses are byte addresses that step by 4. A one-cycle retire strobe marks the final phase of every instruction, so the cycles per instruction can be measured from outside the core.

Encoding: opcode in bits 31:26, first source in 25:21, second source in 20:16, register-register destination in 15:11, register-register function in 5:0, and a 16-bit immediate in 15:0.

Top module: `phase_seq_core`

## Requirements
- R1: While reset is asserted, the instruction address is 0, and retire, data write and data read are all low.
- R2: In the fetch phase, the instruction address output equals the PC. After a non-branching instruction, the next fetch is at PC + 4.
- R3: Opcode 0x00 is a register-register operation. It writes rs1 op rs2 to register bits 15:11. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, and 0x2A signed set-less-than (result 1 or 0).
- R4: A register-immediate operation uses the immediate in bits 15:0, sign-extended to 32 bits, and writes register bits 20:16. The opcodes are 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, and 0x0E xor.
- R5: Opcode 0x23 loads the data word at byte address rs1 + sext(imm) into register bits 20:16. The data read strobe is high for one cycle, in the memory phase.
- R6: Opcode 0x2B writes the register in bits 20:16 to byte address rs1 + sext(imm). The data write strobe is high for exactly one cycle. Read and write are never high together.
- R7: Opcode 0x04 branches when rs1 is zero, and opcode 0x05 branches when rs1 is non-zero. The target is PC + 4 + sext(imm). A branch that is not taken continues at PC + 4.
- R8: Stores, branches and undefined instructions take 4 cycles. ALU operations and loads take 5 cycles. Retire is high for exactly one cycle, in the final phase.
- R9: Register 0 always reads as zero, and writes to it have no effect.
- R10: An undefined opcode, or a register-register operation with an undefined function code, changes no register and no memory. Execution continues at PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Instruction byte address (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_rdata | input | 32 | Load data for dmem_addr, valid in the same cycle |
| retire | output | 1 | High during the last phase of each instruction |

## Verification
The properties take three things for granted about the inputs. Both memories return their word in the same cycle as the address. Branch offsets and load/store addresses are multiples of four. Instruction memory contents do not change while a program runs. The stimulus is a generated program in a word array that holds still after reset, with every offset built as a multiple of four. It sweeps every register-register function and every immediate operation over signed corner operands, then exercises both branch senses, a backward loop, loads with negative offsets, writes to register 0 and undefined encodings. Results become visible through stores, and the length of every retired instruction is measured from the retire strobe.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    PH_FETCH, PH_DECODE, PH_EXEC, PH_MEM, PH_WB
  } phase_t;

  typedef enum logic [2:0] {
    K_NOP, K_RR, K_RI, K_LOAD, K_STORE, K_BRANCH
  } kind_t;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_t;

  typedef struct packed {
    kind_t      kind;
    alu_op_t    op;
    logic [4:0] dst;
    logic       test_nz;
  } ctrl_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic [4:0] rt_field,
  input  logic [4:0] rd_field,
  output ctrl_t      ctl
);
  always_comb begin
    ctl.kind    = K_NOP;
    ctl.op      = ALU_ADD;
    ctl.dst     = rt_field;
    ctl.test_nz = 1'b0;
    case (opcode)
      OP_RR: begin
        ctl.dst  = rd_field;
        ctl.kind = K_RR;
        case (funct)
          FN_ADD:  ctl.op = ALU_ADD;
          FN_SUB:  ctl.op = ALU_SUB;
          FN_AND:  ctl.op = ALU_AND;
          FN_OR:   ctl.op = ALU_OR;
          FN_XOR:  ctl.op = ALU_XOR;
          FN_SLT:  ctl.op = ALU_SLT;
          default: ctl.kind = K_NOP;
        endcase
      end
      OP_ADDI: begin ctl.kind = K_RI; ctl.op = ALU_ADD; end
      OP_SLTI: begin ctl.kind = K_RI; ctl.op = ALU_SLT; end
      OP_ANDI: begin ctl.kind = K_RI; ctl.op = ALU_AND; end
      OP_ORI:  begin ctl.kind = K_RI; ctl.op = ALU_OR;  end
      OP_XORI: begin ctl.kind = K_RI; ctl.op = ALU_XOR; end
      OP_LW:   ctl.kind = K_LOAD;
      OP_SW:   ctl.kind = K_STORE;
      OP_BEQZ: ctl.kind = K_BRANCH;
      OP_BNEZ: begin ctl.kind = K_BRANCH; ctl.test_nz = 1'b1; end
      default: ctl.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/seq_alu.sv
module seq_alu
  import seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_t          op,
  input  logic [XLEN-1:0]  x,
  input  logic [XLEN-1:0]  y,
  output logic [XLEN-1:0]  z
);
  always_comb begin
    case (op)
      ALU_ADD: z = x + y;
      ALU_SUB: z = x - y;
      ALU_AND: z = x & y;
      ALU_OR:  z = x | y;
      ALU_XOR: z = x ^ y;
      ALU_SLT: z = {{(XLEN-1){1'b0}}, $signed(x) < $signed(y)};
      default: z = '0;
    endcase
  end
endmodule

// File: rtl/seq_regfile.sv
module seq_regfile #(
  parameter int XLEN      = 32,
  parameter int REG_COUNT = 32,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   ra_idx,
  input  logic [AW-1:0]   rb_idx,
  output logic [XLEN-1:0] ra_data,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [XLEN-1:0] wr_data
);
  logic [XLEN-1:0] cells [REG_COUNT];

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_cell
    if (g == 0) begin : g_zero
      assign cells[g] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cells[g] <= '0;
        else if (wr_en && wr_idx == AW'(g))
          cells[g] <= wr_data;
      end
    end
  end

  assign ra_data = cells[ra_idx];
  assign rb_data = cells[rb_idx];
endmodule

// File: rtl/seq_phase.sv
module seq_phase
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_t  kind,
  output phase_t phase,
  output logic   retire
);
  logic   needs_wb;
  phase_t nxt;

  assign needs_wb = (kind == K_RR) || (kind == K_RI) || (kind == K_LOAD);

  always_comb begin
    case (phase)
      PH_FETCH:  nxt = PH_DECODE;
      PH_DECODE: nxt = PH_EXEC;
      PH_EXEC:   nxt = PH_MEM;
      PH_MEM:    nxt = needs_wb ? PH_WB : PH_FETCH;
      default:   nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= nxt;
  end

  assign retire = (phase == PH_WB) || (phase == PH_MEM && !needs_wb);
endmodule

// File: rtl/phase_seq_core.sv
module phase_seq_core
  import seq_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              REG_COUNT = 32,
  parameter logic [XLEN-1:0] RESET_PC  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  output logic            dmem_re,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            retire
);
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(4);
  localparam int IMM_W = 16;

  logic [XLEN-1:0] pc, npc, ir, opa, opb, imm, alu_q, lmd;
  logic            cond_q;
  logic [XLEN-1:0] rf_a, rf_b, alu_x, alu_y, alu_z, imm_ext, wb_data;
  logic            zero_test, wb_en;
  alu_op_t         alu_sel;
  ctrl_t           ctl;
  phase_t          phase;

  seq_decode u_dec (
    .opcode   (ir[31:26]),
    .funct    (ir[5:0]),
    .rt_field (ir[20:16]),
    .rd_field (ir[15:11]),
    .ctl      (ctl)
  );

  seq_phase u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (ctl.kind),
    .phase  (phase),
    .retire (retire)
  );

  seq_regfile #(.XLEN(XLEN), .REG_COUNT(REG_COUNT)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_idx  (ir[25:21]),
    .rb_idx  (ir[20:16]),
    .ra_data (rf_a),
    .rb_data (rf_b),
    .wr_en   (wb_en),
    .wr_idx  (ctl.dst),
    .wr_data (wb_data)
  );

  assign imm_ext = {{(XLEN-IMM_W){ir[IMM_W-1]}}, ir[IMM_W-1:0]};

  // Operand steering for the execute phase
  assign alu_x   = (ctl.kind == K_BRANCH) ? npc : opa;
  assign alu_y   = (ctl.kind == K_RR) ? opb : imm;
  assign alu_sel = (ctl.kind == K_RR || ctl.kind == K_RI) ? ctl.op : ALU_ADD;
  assign zero_test = ctl.test_nz ? (opa != '0) : (opa == '0);

  seq_alu #(.XLEN(XLEN)) u_alu (
    .op (alu_sel),
    .x  (alu_x),
    .y  (alu_y),
    .z  (alu_z)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc     <= RESET_PC;
      npc    <= '0;
      ir     <= '0;
      opa    <= '0;
      opb    <= '0;
      imm    <= '0;
      alu_q  <= '0;
      cond_q <= 1'b0;
      lmd    <= '0;
    end else begin
      case (phase)
        PH_FETCH: begin
          ir  <= imem_rdata;
          npc <= pc + WORD_STEP;
        end
        PH_DECODE: begin
          opa <= rf_a;
          opb <= rf_b;
          imm <= imm_ext;
        end
        PH_EXEC: begin
          alu_q  <= alu_z;
          cond_q <= zero_test;
        end
        PH_MEM: begin
          if (ctl.kind == K_LOAD) lmd <= dmem_rdata;
          pc <= (ctl.kind == K_BRANCH && cond_q) ? alu_q : npc;
        end
        default: ;
      endcase
    end
  end

  assign wb_en   = (phase == PH_WB) &&
                   (ctl.kind == K_RR || ctl.kind == K_RI || ctl.kind == K_LOAD);
  assign wb_data = (ctl.kind == K_LOAD) ? lmd : alu_q;

  assign imem_addr  = pc;
  assign dmem_addr  = alu_q;
  assign dmem_wdata = opb;
  assign dmem_we    = (phase == PH_MEM) && (ctl.kind == K_STORE);
  assign dmem_re    = (phase == PH_MEM) && (ctl.kind == K_LOAD);
endmodule

// File: rtl/phase_seq_core_checker.sv
module phase_seq_core_checker (
  input logic clk,
  input logic rst_n,
  input logic retire,
  input logic dmem_we,
  input logic dmem_re
);
  logic [2:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap <= '0;
    else if (retire)     gap <= '0;
    else if (gap != 3'd7) gap <= gap + 3'd1;
  end

  assert_retire_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> !retire);

  assert_len_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gap <= 3'd4);

  assert_len_min_R8: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> gap >= 3'd3);

  assert_store_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> retire);

  assert_load_then_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_re |=> retire);

  assert_mem_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(dmem_we && dmem_re));
endmodule

bind phase_seq_core phase_seq_core_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .retire  (retire),
  .dmem_we (dmem_we),
  .dmem_re (dmem_re)
);

// File: tb/phase_seq_core_bench.sv
`timescale 1ns/1ps
module phase_seq_core_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re, retire;

  always #2 clk = ~clk;

  logic [31:0] imem [512];
  logic [31:0] dmem [64];
  int          exp_len [512];
  logic [31:0] es_addr [$];
  logic [31:0] es_data [$];
  string       es_tag  [$];
  int n_chk = 0, n_fail = 0, si = 0, p = 0, sa = 0;

  assign imem_rdata = imem[imem_addr[10:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  phase_seq_core u_phase_seq_core (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .retire(retire)
  );

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction
  function automatic logic [31:0] enc_r(input int rs, rt, rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, rt, input logic [15:0] im);
    return {op, 5'(rs), 5'(rt), im};
  endfunction
  function automatic logic [31:0] ref_op(input int sel, input logic [31:0] a, b);
    case (sel)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      default: return {31'd0, $signed(a) < $signed(b)};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w, input int len);
    imem[p] = w; exp_len[p] = len; p++;
  endtask
  task automatic want(input logic [31:0] a, d, input string tag);
    es_addr.push_back(a); es_data.push_back(d); es_tag.push_back(tag);
  endtask
  task automatic do_sw(input int rt, input logic [31:0] val, input string tag);
    logic [31:0] a;
    a = 32'd64 + 32'((sa % 48) * 4);
    sa++;
    put(enc_i(6'h2B, 0, rt, a[15:0]), 4);
    want(a, val, tag);
  endtask

  // Monitor: instruction lengths and store traffic
  bit start = 1'b1;
  int cur_idx = 0, cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (start) begin cur_idx = int'(imem_addr[10:2]); start = 1'b0; end
      cyc++;
      if (dmem_we) begin
        if (si < es_addr.size()) begin
          chk(dmem_addr == es_addr[si], {es_tag[si], " addr"}, dmem_addr, es_addr[si]);
          chk(dmem_wdata == es_data[si], {es_tag[si], " data"}, dmem_wdata, es_data[si]);
          si++;
        end else
          chk(1'b0, "R10 unexpected store", dmem_addr, 32'hFFFF_FFFF);
        dmem[dmem_addr[7:2]] = dmem_wdata;
      end
      if (retire) begin
        chk(cyc == exp_len[cur_idx], $sformatf("R8 length at word %0d", cur_idx),
            32'(cyc), 32'(exp_len[cur_idx]));
        cyc = 0;
        start = 1'b1;
      end
    end
  end

  logic [15:0] vals [4];
  localparam logic [5:0] FNS [6] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
  localparam logic [5:0] IOPS [5] = '{6'h08, 6'h0E, 6'h0C, 6'h0D, 6'h0A};
  localparam int         ISEL [5] = '{0, 4, 2, 3, 5};

  initial begin
    logic [31:0] r1v;
    int wd;
    vals[0] = 16'd3; vals[1] = 16'hFFFE; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    for (int i = 0; i < 512; i++) begin imem[i] = 32'd0; exp_len[i] = 4; end
    for (int i = 0; i < 64; i++) dmem[i] = 32'hA500_0000 ^ (32'(i) * 32'h0101_0101);
    r1v = 32'd0;

    // R3: register-register sweep
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        put(enc_i(6'h08, 0, 1, vals[i]), 5);
        put(enc_i(6'h08, 0, 2, vals[j]), 5);
        for (int f = 0; f < 6; f++) begin
          put(enc_r(1, 2, 3 + f, FNS[f]), 5);
          do_sw(3 + f, ref_op(f, sx(vals[i]), sx(vals[j])), $sformatf("R3 fn%0d", f));
        end
      end
    // R4: register-immediate sweep
    for (int i = 0; i < 4; i++) begin
      put(enc_i(6'h08, 0, 1, vals[i]), 5);
      r1v = sx(vals[i]);
      for (int q = 0; q < 5; q++) begin
        put(enc_i(IOPS[q], 1, 15 + q, 16'hF0F3), 5);
        do_sw(15 + q, ref_op(ISEL[q], r1v, sx(16'hF0F3)), $sformatf("R4 op%0d", q));
      end
    end
    // R5: loads, direct and with negative offset
    for (int k = 0; k < 8; k++) begin
      put(enc_i(6'h23, 0, 9, 16'(k * 4)), 5);
      do_sw(9, dmem[k], "R5 load");
    end
    put(enc_i(6'h08, 0, 10, 16'd32), 5);
    put(enc_i(6'h23, 10, 11, 16'hFFE4), 5);
    do_sw(11, dmem[1], "R5 negative offset");
    // R9: register 0
    put(enc_i(6'h08, 0, 0, 16'd77), 5);
    do_sw(0, 32'd0, "R9 addi to r0");
    put(enc_r(1, 1, 0, 6'h20), 5);
    do_sw(0, 32'd0, "R9 add to r0");
    // R10: undefined encodings
    put(32'hFC21_0000, 4);
    do_sw(1, r1v, "R10 undefined opcode");
    put(enc_r(1, 1, 1, 6'h3F), 4);
    do_sw(1, r1v, "R10 undefined funct");
    // R7: branches
    put(enc_i(6'h08, 0, 12, 16'd0), 5);
    put(enc_i(6'h08, 0, 13, 16'd1), 5);
    put(enc_i(6'h04, 12, 0, 16'd4), 4);
    put(enc_i(6'h2B, 0, 13, 16'd60), 4);
    do_sw(13, 32'd1, "R7 beqz taken");
    put(enc_i(6'h04, 13, 0, 16'd4), 4);
    do_sw(13, 32'd1, "R7 beqz not taken");
    put(enc_i(6'h05, 13, 0, 16'd4), 4);
    put(enc_i(6'h2B, 0, 13, 16'd60), 4);
    do_sw(13, 32'd1, "R7 bnez taken");
    put(enc_i(6'h05, 12, 0, 16'd4), 4);
    do_sw(12, 32'd0, "R7 bnez not taken");
    // R7/R2: backward counted loop
    put(enc_i(6'h08, 0, 14, 16'd3), 5);
    put(enc_i(6'h08, 14, 14, 16'hFFFF), 5);
    put(enc_i(6'h2B, 0, 14, 16'd56), 4);
    put(enc_i(6'h05, 14, 0, 16'hFFF4), 4);
    want(32'd56, 32'd2, "R7 loop pass 1");
    want(32'd56, 32'd1, "R7 loop pass 2");
    want(32'd56, 32'd0, "R7 loop exit");
    // final self loop
    put(enc_i(6'h04, 0, 0, 16'hFFFC), 4);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(imem_addr == 32'd0, "R1 pc", imem_addr, 32'd0);
    chk(retire == 1'b0, "R1 retire", 32'(retire), 32'd0);
    chk(dmem_we == 1'b0 && dmem_re == 1'b0, "R1 strobes", 32'({dmem_we, dmem_re}), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    wd = 0;
    while (si < es_addr.size() && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 20000) chk(1'b0, "R8 watchdog stores seen", 32'(si), 32'(es_addr.size()));
    // R2: self loop keeps its address; length checks continue
    repeat (30) @(negedge clk);
    chk(imem_addr == 32'(4 * (p - 1)), "R2 final pc", imem_addr, 32'(4 * (p - 1)));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule